// File: doc/BRIEF.md
# Variable-Length Bytecode Instruction Decoder

This block sits between an instruction prefetch path and the issue logic of a byte-coded stack machine. Bytes come in one at a time through a valid/ready handshake. The block collects them until one whole instruction is held, which is one to five bytes. It takes the instruction length from the opcode byte alone, as soon as that byte arrives. When the instruction is complete, the block presents it in a single output slot.

The output slot carries the following:
- the opcode;
- a format class and the length;
- the operand bytes as 32-bit zero-extended and sign-extended values;
- the 16-bit operand;
- the unaligned, most-significant-byte-first 32-bit operand;
- the two nibbles of the second operand byte;
- two flags, one for opcodes that take the extended-operation trap and one for reserved opcodes.

The slot holds its contents until the consumer accepts them. While the slot is full, no input byte is taken.

Top module: `bytecode_decoder`

## Requirements
- R1: `out_len` is 1 for opcodes 000–037 and 100–177 octal, 5 for 040–077, 2 for 200–277 and 3 for 300–377. The block takes exactly that many bytes for the instruction, opcode first.
- R2: `in_ready` is low whenever `out_valid` is high. `out_valid` rises in the cycle after the last byte is taken. While `out_ready` is low, every output holds steady. `out_valid` falls in the cycle after it is accepted. Idle cycles between the bytes of one instruction are allowed.
- R3: `alpha_z`/`alpha_s` are byte 1 (the first byte after the opcode), zero- and sign-extended to 32 bits. `beta_z`/`beta_s` are byte 2, extended the same way.
- R4: `ab_z`/`ab_s` are byte1*256+byte2, zero- and sign-extended to 32 bits.
- R5: `quad` is {byte1, byte2, byte3, byte4}, with byte 1 as the most significant.
- R6: `beta_hi` is bits 7:4 of byte 2 and `beta_lo` is bits 3:0.
- R7: Operand bytes beyond the instruction length read as zero in every field.
- R8: `out_fmt` encodes the format class as follows:
  - 0: implicit, for 000–037 and 100–137.
  - 1: quad byte, for 040–077.
  - 2: local register, for 140–177.
  - 3: quick register, for 200–207.
  - 4: byte, for 210–237.
  - 5: local register plus byte, for 240–277.
  - 6: register-register, for 300–317.
  - 7: double byte, for 320–327, 334–337 and 370–377.
  - 8: two-register plus byte, for 330–333.
  - 9: register jump, for 340–357.
  - 10: jump byte-byte, for 360–367.
- R9: `out_xop` is high exactly for these opcodes (octal):
  - 000–017;
  - 034–057;
  - 060 and 063;
  - 070–077;
  - 112;
  - 120–123 and 125;
  - 130–137;
  - 215, 217 and 223;
  - 234–236;
  - 364–367;
  - 374–377.
- R10: `out_rsvd` is high exactly for opcodes 311, 313, 337, 340, 344, 350 and 354 octal.
- R11: The no-op jumps at 126, 226, 326 and 066 octal have lengths 1, 2, 3 and 5. Neither flag is set for them.
- R12: A synchronous `rst` clears `out_valid` and discards any partly collected instruction. The next byte taken is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Byte taken at the edge when both are high |
| out_valid | output | 1 | Complete instruction present |
| out_ready | input | 1 | Consumer accepts the instruction |
| out_opcode | output | 8 | Opcode byte |
| out_len | output | 3 | Instruction length in bytes |
| out_fmt | output | 4 | Format class (R8) |
| out_xop | output | 1 | Extended-operation trap opcode |
| out_rsvd | output | 1 | Reserved opcode |
| alpha_z | output | 32 | Byte 1 zero-extended |
| alpha_s | output | 32 | Byte 1 sign-extended |
| beta_z | output | 32 | Byte 2 zero-extended |
| beta_s | output | 32 | Byte 2 sign-extended |
| ab_z | output | 32 | Halfword operand zero-extended |
| ab_s | output | 32 | Halfword operand sign-extended |
| quad | output | 32 | 32-bit operand |
| beta_hi | output | 4 | Upper nibble of byte 2 |
| beta_lo | output | 4 | Lower nibble of byte 2 |

## Verification
Every result is due one clock edge after the last byte of the instruction is taken. The flag, format and field outputs are combinational views of the registered bytes, so they become valid in the same cycle as `out_valid`. The bench drives bytes at the falling edge, so each byte is taken at the next rising edge. It samples all outputs at the falling edge after the final byte. At that point it also checks that `in_ready` is low and that the slot stays unchanged through stall cycles. It then releases the slot and expects `out_valid` low one edge later. A byte-wait bound turns a wrong length into a reported failure rather than a stall.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [3:0] {
    FMT_IMPL   = 4'd0,
    FMT_QUAD   = 4'd1,
    FMT_LREG   = 4'd2,
    FMT_QREG   = 4'd3,
    FMT_BYTE   = 4'd4,
    FMT_LRBYTE = 4'd5,
    FMT_RREG   = 4'd6,
    FMT_DBL    = 4'd7,
    FMT_LRRB   = 4'd8,
    FMT_RJMP   = 4'd9,
    FMT_JBB    = 4'd10
  } fmt_e;

  // Length depends only on the top three opcode bits.
  function automatic logic [2:0] op_len(input logic [7:0] op);
    case (op[7:6])
      2'b00:   return op[5] ? 3'd5 : 3'd1;
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic fmt_e op_fmt(input logic [7:0] op);
    if (op <= 8'o037)      return FMT_IMPL;
    else if (op <= 8'o077) return FMT_QUAD;
    else if (op <= 8'o137) return FMT_IMPL;
    else if (op <= 8'o177) return FMT_LREG;
    else if (op <= 8'o207) return FMT_QREG;
    else if (op <= 8'o237) return FMT_BYTE;
    else if (op <= 8'o277) return FMT_LRBYTE;
    else if (op <= 8'o317) return FMT_RREG;
    else if (op <= 8'o327) return FMT_DBL;
    else if (op <= 8'o333) return FMT_LRRB;
    else if (op <= 8'o337) return FMT_DBL;
    else if (op <= 8'o357) return FMT_RJMP;
    else if (op <= 8'o367) return FMT_JBB;
    else                   return FMT_DBL;
  endfunction

  function automatic logic op_is_xop(input logic [7:0] op);
    return op inside {[8'o000:8'o017], [8'o034:8'o057], 8'o060, 8'o063,
                      [8'o070:8'o077], 8'o112, [8'o120:8'o123], 8'o125,
                      [8'o130:8'o137], 8'o215, 8'o217, 8'o223,
                      [8'o234:8'o236], [8'o364:8'o367], [8'o374:8'o377]};
  endfunction

  function automatic logic op_is_rsvd(input logic [7:0] op);
    return op inside {8'o311, 8'o313, 8'o337, 8'o340, 8'o344, 8'o350, 8'o354};
  endfunction

  function automatic logic [31:0] zext8(input logic [7:0] v);
    return {24'd0, v};
  endfunction

  function automatic logic [31:0] sext8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

endpackage

// File: rtl/bcd_assembler.sv
module bcd_assembler
  import bcd_pkg::*;
#(
  parameter int MAX_LEN = 5,
  localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [7:0]             in_byte,
  output logic                   in_ready,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [MAX_LEN-1:0][7:0] bytes_o,
  output logic [CNT_W-1:0]       len_o
);

  logic [MAX_LEN-1:0][7:0] buf_q;
  logic [CNT_W-1:0]        cnt_q, len_q, len_now;
  logic                    vld_q;

  // Named events for the assertions
  logic take_byte, take_first, take_last, slot_fire;

  assign in_ready   = !vld_q;
  assign take_byte  = in_valid && in_ready;
  assign take_first = take_byte && (cnt_q == '0);
  assign len_now    = (cnt_q == '0) ? CNT_W'(op_len(in_byte)) : len_q;
  assign take_last  = take_byte && ((cnt_q + CNT_W'(1)) == len_now);
  assign slot_fire  = vld_q && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      cnt_q <= '0;
      len_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (slot_fire) vld_q <= 1'b0;
      if (take_byte) begin
        if (take_first) begin
          buf_q <= '0;
          len_q <= len_now;
        end
        buf_q[cnt_q] <= in_byte;
        if (take_last) begin
          cnt_q <= '0;
          vld_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign out_valid = vld_q;
  assign bytes_o   = buf_q;
  assign len_o     = len_q;

  a_r2_no_take_when_full: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  a_r2_hold_slot: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(buf_q) && $stable(len_q)));
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    slot_fire |=> !out_valid);
  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && cnt_q == '0));
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q < len_q));

endmodule

// File: rtl/bcd_classify.sv
module bcd_classify
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       valid,
  input  logic [7:0] opcode,
  output logic [2:0] len,
  output logic [3:0] fmt,
  output logic       xop,
  output logic       rsvd
);

  assign len  = op_len(opcode);
  assign fmt  = op_fmt(opcode);
  assign xop  = op_is_xop(opcode);
  assign rsvd = op_is_rsvd(opcode);

  a_r9_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    valid |-> !(xop && rsvd));
  a_r1_len_legal: assert property (@(posedge clk) disable iff (rst)
    valid |-> (len inside {3'd1, 3'd2, 3'd3, 3'd5}));
  a_r8_quad_fmt_len: assert property (@(posedge clk) disable iff (rst)
    (valid && fmt == FMT_QUAD) |-> (len == 3'd5));

endmodule

// File: rtl/bcd_fields.sv
module bcd_fields
  import bcd_pkg::*;
(
  input  logic [7:0]  b1,
  input  logic [7:0]  b2,
  input  logic [7:0]  b3,
  input  logic [7:0]  b4,
  output logic [31:0] alpha_z,
  output logic [31:0] alpha_s,
  output logic [31:0] beta_z,
  output logic [31:0] beta_s,
  output logic [31:0] ab_z,
  output logic [31:0] ab_s,
  output logic [31:0] quad,
  output logic [3:0]  beta_hi,
  output logic [3:0]  beta_lo
);

  assign alpha_z = zext8(b1);
  assign alpha_s = sext8(b1);
  assign beta_z  = zext8(b2);
  assign beta_s  = sext8(b2);
  assign ab_z    = {16'd0, b1, b2};
  assign ab_s    = sext16({b1, b2});
  assign quad    = {b1, b2, b3, b4};
  assign beta_hi = b2[7:4];
  assign beta_lo = b2[3:0];

endmodule

// File: rtl/bytecode_decoder.sv
module bytecode_decoder
  import bcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_opcode,
  output logic [2:0]  out_len,
  output logic [3:0]  out_fmt,
  output logic        out_xop,
  output logic        out_rsvd,
  output logic [31:0] alpha_z,
  output logic [31:0] alpha_s,
  output logic [31:0] beta_z,
  output logic [31:0] beta_s,
  output logic [31:0] ab_z,
  output logic [31:0] ab_s,
  output logic [31:0] quad,
  output logic [3:0]  beta_hi,
  output logic [3:0]  beta_lo
);

  localparam int MAX_LEN = 5;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [MAX_LEN-1:0][7:0] bytes;
  logic [CNT_W-1:0]        held_len;

  bcd_assembler #(.MAX_LEN(MAX_LEN)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .bytes_o   (bytes),
    .len_o     (held_len)
  );

  assign out_opcode = bytes[0];

  bcd_classify u_cls (
    .clk    (clk),
    .rst    (rst),
    .valid  (out_valid),
    .opcode (bytes[0]),
    .len    (out_len),
    .fmt    (out_fmt),
    .xop    (out_xop),
    .rsvd   (out_rsvd)
  );

  bcd_fields u_fld (
    .b1      (bytes[1]),
    .b2      (bytes[2]),
    .b3      (bytes[3]),
    .b4      (bytes[4]),
    .alpha_z (alpha_z),
    .alpha_s (alpha_s),
    .beta_z  (beta_z),
    .beta_s  (beta_s),
    .ab_z    (ab_z),
    .ab_s    (ab_s),
    .quad    (quad),
    .beta_hi (beta_hi),
    .beta_lo (beta_lo)
  );

  a_r1_len_agrees: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (CNT_W'(out_len) == held_len));
  a_r7_short_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 3'd1) |-> (quad == 32'd0));
  a_r7_two_byte_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 3'd2) |-> (quad[23:0] == 24'd0));

endmodule

// File: tb/bytecode_decoder_test.sv
module bytecode_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'd0;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_opcode;
  logic [2:0]  out_len;
  logic [3:0]  out_fmt;
  logic        out_xop, out_rsvd;
  logic [31:0] alpha_z, alpha_s, beta_z, beta_s, ab_z, ab_s, quad;
  logic [3:0]  beta_hi, beta_lo;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bytecode_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_len(out_len), .out_fmt(out_fmt),
    .out_xop(out_xop), .out_rsvd(out_rsvd), .alpha_z(alpha_z),
    .alpha_s(alpha_s), .beta_z(beta_z), .beta_s(beta_s), .ab_z(ab_z),
    .ab_s(ab_s), .quad(quad), .beta_hi(beta_hi), .beta_lo(beta_lo)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected values restated from the requirements
  function automatic int exp_len(input int op);
    if (op < 32) return 1;
    if (op < 64) return 5;
    if (op < 128) return 1;
    if (op < 192) return 2;
    return 3;
  endfunction

  function automatic int exp_fmt(input int op);
    int row = op / 8;
    case (row)
      0, 1, 2, 3, 8, 9, 10, 11:        return 0;
      4, 5, 6, 7:                      return 1;
      12, 13, 14, 15:                  return 2;
      16:                              return 3;
      17, 18, 19:                      return 4;
      20, 21, 22, 23:                  return 5;
      24, 25:                          return 6;
      26, 31:                          return 7;
      27:                              return ((op % 8) < 4) ? 8 : 7;
      28, 29:                          return 9;
      30:                              return 10;
      default:                         return 15;
    endcase
  endfunction

  function automatic bit exp_xop(input int op);
    int m;
    case (op / 8)
      0, 1, 4, 5, 7, 11: m = 8'hFF;
      3, 30, 31:         m = 8'hF0;
      6:                 m = 8'h09;
      9:                 m = 8'h04;
      10:                m = 8'h2F;
      17:                m = 8'hA0;
      18:                m = 8'h08;
      19:                m = 8'h70;
      default:           m = 0;
    endcase
    return m[op % 8];
  endfunction

  function automatic bit exp_rsvd(input int op);
    int m;
    case (op / 8)
      25:      m = 8'h0A;
      27:      m = 8'h80;
      28, 29:  m = 8'h11;
      default: m = 0;
    endcase
    return m[op % 8];
  endfunction

  function automatic logic [31:0] sx(input int v, input int bits);
    int r = v;
    if (v >= (1 << (bits - 1))) r = v - (1 << bits);
    return 32'(r);
  endfunction

  // Offer one byte; returns 0 if the design never becomes ready
  task automatic push(input logic [7:0] b, input bit gap, output bit ok);
    int waits = 0;
    @(negedge clk);
    if (gap) @(negedge clk);
    while (!in_ready && waits < 8) begin
      @(negedge clk);
      waits++;
    end
    ok = in_ready;
    if (ok) begin
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic release_slot();
    for (int k = 0; k < 4 && out_valid; k++) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic run_op(input int op, input bit stall, input bit gap);
    logic [7:0] ob [5];
    int n, a, b, g, d;
    bit ok = 1'b1, okb;
    ob[0] = 8'(op);
    ob[1] = 8'(op ^ 8'hA5);
    ob[2] = 8'(op + 8'h39);
    ob[3] = 8'(~op);
    ob[4] = 8'(op * 7 + 1);
    n = exp_len(op);
    for (int i = 0; i < n; i++) begin
      push(ob[i], gap && i > 0, okb);
      ok &= okb;
    end
    check(ok && out_valid && !in_ready, "R2", {ok, out_valid, in_ready}, 3'b110);
    a = (n > 1) ? int'(ob[1]) : 0;
    b = (n > 2) ? int'(ob[2]) : 0;
    g = (n > 4) ? int'(ob[3]) : 0;
    d = (n > 4) ? int'(ob[4]) : 0;
    check(out_opcode == 8'(op) && int'(out_len) == n, "R1",
          {out_opcode, 5'd0, out_len}, {8'(op), 8'(n)});
    check(int'(out_fmt) == exp_fmt(op), "R8", out_fmt, exp_fmt(op));
    check(out_xop == exp_xop(op), "R9", out_xop, exp_xop(op));
    check(out_rsvd == exp_rsvd(op), "R10", out_rsvd, exp_rsvd(op));
    check(alpha_z == 32'(a) && alpha_s == sx(a, 8) &&
          beta_z == 32'(b) && beta_s == sx(b, 8), "R3",
          {alpha_s, beta_s}, {sx(a, 8), sx(b, 8)});
    check(ab_z == 32'(a * 256 + b) && ab_s == sx(a * 256 + b, 16), "R4",
          {ab_z, ab_s}, {32'(a * 256 + b), sx(a * 256 + b, 16)});
    check(quad == 32'(a) * 32'd16777216 + 32'(b * 65536 + g * 256 + d), "R5",
          quad, 32'(a) * 32'd16777216 + 32'(b * 65536 + g * 256 + d));
    check(int'(beta_hi) == b / 16 && int'(beta_lo) == b % 16, "R6",
          {beta_hi, beta_lo}, 8'(b));
    if (n == 1)
      check(alpha_z == 0 && beta_z == 0 && ab_z == 0 && quad == 0, "R7",
            {ab_z, quad}, 64'd0);
    if (stall) begin
      @(negedge clk);
      @(negedge clk);
      check(out_valid && !in_ready && out_opcode == 8'(op) && ab_z == 32'(a * 256 + b),
            "R2 hold", {out_valid, in_ready, out_opcode}, {2'b10, 8'(op)});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R2 release", {out_valid, in_ready}, 2'b01);
    release_slot();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit okb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!out_valid && in_ready, "R12 reset state", {out_valid, in_ready}, 2'b01);

    for (int op = 0; op < 256; op++)
      run_op(op, (op % 16) == 5, (op % 3) == 1);

    // R11: no-op jumps
    begin
      int jc[4] = '{8'o126, 8'o226, 8'o326, 8'o066};
      int jl[4] = '{1, 2, 3, 5};
      for (int i = 0; i < 4; i++) begin
        for (int k = 0; k < jl[i]; k++) begin
          push(8'(jc[i] + k * 17), 1'b0, okb);
        end
        check(out_valid && int'(out_len) == jl[i] && !out_xop && !out_rsvd, "R11",
              {out_valid, out_len, out_xop, out_rsvd}, {1'b1, 3'(jl[i]), 2'b00});
        release_slot();
      end
    end

    // R12: reset in the middle of a 5-byte instruction
    push(8'o040, 1'b0, okb);
    push(8'h12, 1'b0, okb);
    push(8'h34, 1'b0, okb);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!out_valid && in_ready, "R12 mid reset", {out_valid, in_ready}, 2'b01);
    push(8'o100, 1'b0, okb);
    check(out_valid && out_opcode == 8'o100 && out_len == 3'd1 && quad == 0, "R12 restart",
          {out_valid, out_opcode, out_len}, {1'b1, 8'o100, 3'd1});
    release_slot();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule